// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block decides what drives the count-enable and the gate of each channel in a small group of counters. A decade prescaler chain runs off the base clock, nominally 10 MHz. Each stage divides by ten, so the chain gives 1 MHz, 100 kHz, 10 kHz and 1 kHz enable pulses. These pulses last one base-clock cycle. The counters themselves sit outside the block. Their outputs come back in, so one channel can be clocked or gated by a neighbour.

Software programs two byte-wide selectors, one for clocks and one for gates. Each write carries a channel index and a source code, and it changes only that channel's selection. For each channel, the block gives:

- a one-cycle clock-enable taken from one of these sources:
  - the base clock,
  - a prescaler tap,
  - the rising edge of the output of the channel below it (wrapping modulo the group size),
  - a synchronized external clock pin.
- a gate level taken from one of these sources:
  - a constant high or low,
  - a synchronized external gate pin,
  - the inverted output of the channel two below it (wrapping modulo the group size).

Top module: `ctr_src_router`

## Requirements
- R1: After reset, every channel selects the base clock, so its clock-enable is high on every cycle, and every gate is high.
- R2: A configuration byte carries the channel index in bits [4:3] and the source code in bits [2:0]. A write changes only the addressed channel. A write whose index is NUM_CH or above changes no channel.
- R3: Clock codes 1, 2, 3, 4 and 5 give enable pulses one cycle wide, with periods of 1, 10, 100, 1000 and 10000 base-clock cycles.
- R4: Clock code 0 is reserved and gives no enable pulse at all.
- R5: Clock code 6 on channel n gives a one-cycle enable in the first cycle in which the output of counter (n-1) mod NUM_CH is high after being low. The enable then stays low while that output stays high.
- R6: Clock code 7 on channel n gives one enable pulse for each rising edge of external clock pin n. The pulse is high in the cycle that follows the second clock edge after the pin is seen high.
- R7: Gate code 0 holds the gate high, and gate code 1 holds it low.
- R8: Gate code 2 on channel n follows external gate pin n, delayed by two clock edges.
- R9: Gate code 3 on channel n gives the inverse of the output of counter (n-2) mod NUM_CH, in the same cycle.
- R10: Gate codes 4 to 7 are undefined and hold the gate low.
- R11: The clock selector and the gate selector are independent. A write to one leaves the routing set by the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, nominally 10 MHz |
| rst_n | input | 1 | Active-low reset |
| clk_cfg_we | input | 1 | Write strobe for the clock selector |
| clk_cfg_byte | input | 8 | Clock selector byte: channel in [4:3], code in [2:0] |
| gate_cfg_we | input | 1 | Write strobe for the gate selector |
| gate_cfg_byte | input | 8 | Gate selector byte: channel in [4:3], code in [2:0] |
| ctr_out | input | NUM_CH | Outputs of the external counters |
| ext_clk | input | NUM_CH | Asynchronous external clock pins |
| ext_gate | input | NUM_CH | Asynchronous external gate pins |
| ch_clk_en | output | NUM_CH | Per-channel count-enable pulse |
| ch_gate | output | NUM_CH | Per-channel gate level |

## Verification
Most faults in the held selector state show at the ports in the same cycle:

- A corrupted channel code shows at once as a gate at the wrong level, or as a clock-enable that is high when it should be low.
- A write that reaches the wrong channel changes the enable rate of a channel the write did not address.

Faults in the other state take longer to appear:

- A prescaler counter that counts wrong only shows as a pulse count that is off over a window of one tap period or more. For this reason the rates are counted over whole multiples of each period.
- A synchronizer with the wrong depth moves the external-pin response by one cycle. This is caught by sampling each cycle just after the pin change.

// File: rtl/ctr_route_pkg.sv
package ctr_route_pkg;

   localparam int CFG_W    = 8;
   localparam int CODE_W   = 3;
   localparam int SEL_W    = 2;
   localparam int SEL_LSB  = 3;
   localparam int NUM_TAPS = 5;

   // clock source codes
   localparam logic [CODE_W-1:0] CK_RSVD = 3'd0;
   localparam logic [CODE_W-1:0] CK_BASE = 3'd1;
   localparam logic [CODE_W-1:0] CK_D1   = 3'd2;
   localparam logic [CODE_W-1:0] CK_D2   = 3'd3;
   localparam logic [CODE_W-1:0] CK_D3   = 3'd4;
   localparam logic [CODE_W-1:0] CK_D4   = 3'd5;
   localparam logic [CODE_W-1:0] CK_PREV = 3'd6;
   localparam logic [CODE_W-1:0] CK_EXT  = 3'd7;

   // gate source codes
   localparam logic [CODE_W-1:0] GT_HIGH  = 3'd0;
   localparam logic [CODE_W-1:0] GT_LOW   = 3'd1;
   localparam logic [CODE_W-1:0] GT_EXT   = 3'd2;
   localparam logic [CODE_W-1:0] GT_NPRV2 = 3'd3;

   function automatic logic [SEL_W-1:0] cfg_sel(input logic [CFG_W-1:0] b);
      return b[SEL_LSB +: SEL_W];
   endfunction

   function automatic logic [CODE_W-1:0] cfg_code(input logic [CFG_W-1:0] b);
      return b[CODE_W-1:0];
   endfunction

endpackage

// File: rtl/ctr_route_prescale.sv
module ctr_route_prescale #(
   parameter int DIV    = 10,
   parameter int STAGES = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [STAGES:0] tap
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   assign tap[0] = 1'b1;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (tap[k]) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         end
      end
      assign tap[k+1] = tap[k] && (cnt == LAST);
   end
endmodule

// File: rtl/ctr_route_sync.sv
module ctr_route_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise
);
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '0;
         else        sr <= {sr[STAGES-1:0], din[b]};
      end
      assign lvl[b]  = sr[STAGES-1];
      assign rise[b] = sr[STAGES-1] & ~sr[STAGES];
   end
endmodule

// File: rtl/ctr_route_cfg.sv
module ctr_route_cfg
   import ctr_route_pkg::*;
#(
   parameter int                NUM_CH   = 3,
   parameter logic [CODE_W-1:0] RST_CODE = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [CFG_W-1:0]         wbyte,
   output logic [NUM_CH*CODE_W-1:0] codes
);
   logic [SEL_W-1:0]  w_sel;
   logic [CODE_W-1:0] w_code;

   assign w_sel  = cfg_sel(wbyte);
   assign w_code = cfg_code(wbyte);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            codes[i*CODE_W +: CODE_W] <= RST_CODE;
         end else if (we && (w_sel == SEL_W'(i))) begin
            codes[i*CODE_W +: CODE_W] <= w_code;
         end
      end
   end
endmodule

// File: rtl/ctr_route_lane.sv
module ctr_route_lane
   import ctr_route_pkg::*;
(
   input  logic [NUM_TAPS-1:0] taps,
   input  logic [CODE_W-1:0]   clk_code,
   input  logic [CODE_W-1:0]   gate_code,
   input  logic                prev_rise,
   input  logic                ext_rise,
   input  logic                ext_lvl,
   input  logic                prev2_out,
   output logic                clk_en,
   output logic                gate
);
   always_comb begin
      unique case (clk_code)
         CK_BASE: clk_en = taps[0];
         CK_D1:   clk_en = taps[1];
         CK_D2:   clk_en = taps[2];
         CK_D3:   clk_en = taps[3];
         CK_D4:   clk_en = taps[4];
         CK_PREV: clk_en = prev_rise;
         CK_EXT:  clk_en = ext_rise;
         default: clk_en = 1'b0;
      endcase
   end

   always_comb begin
      case (gate_code)
         GT_HIGH:  gate = 1'b1;
         GT_LOW:   gate = 1'b0;
         GT_EXT:   gate = ext_lvl;
         GT_NPRV2: gate = ~prev2_out;
         default:  gate = 1'b0;
      endcase
   end
endmodule

// File: rtl/ctr_src_router.sv
module ctr_src_router
   import ctr_route_pkg::*;
#(
   parameter int NUM_CH      = 3,
   parameter int PRE_DIV     = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_cfg_we,
   input  logic [7:0]        clk_cfg_byte,
   input  logic              gate_cfg_we,
   input  logic [7:0]        gate_cfg_byte,
   input  logic [NUM_CH-1:0] ctr_out,
   input  logic [NUM_CH-1:0] ext_clk,
   input  logic [NUM_CH-1:0] ext_gate,
   output logic [NUM_CH-1:0] ch_clk_en,
   output logic [NUM_CH-1:0] ch_gate
);
   localparam int STAGES = NUM_TAPS - 1;

   if (NUM_CH < 1 || NUM_CH > (1 << SEL_W)) begin : g_bad_ch
      $error("NUM_CH must fit the channel field");
   end
   if (PRE_DIV < 2) begin : g_bad_div
      $error("PRE_DIV must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_TAPS-1:0]      taps;
   logic [NUM_CH*CODE_W-1:0] clk_codes;
   logic [NUM_CH*CODE_W-1:0] gate_codes;
   logic [NUM_CH-1:0]        ctr_q;
   logic [NUM_CH-1:0]        ctr_rise;
   logic [NUM_CH-1:0]        eclk_lvl;
   logic [NUM_CH-1:0]        eclk_rise;
   logic [NUM_CH-1:0]        egate_lvl;
   logic [NUM_CH-1:0]        egate_rise;

   ctr_route_prescale #(.DIV(PRE_DIV), .STAGES(STAGES)) u_pre (
      .clk(clk), .rst_n(rst_n), .tap(taps)
   );

   ctr_route_cfg #(.NUM_CH(NUM_CH), .RST_CODE(CK_BASE)) u_clk_cfg (
      .clk(clk), .rst_n(rst_n), .we(clk_cfg_we), .wbyte(clk_cfg_byte),
      .codes(clk_codes)
   );

   ctr_route_cfg #(.NUM_CH(NUM_CH), .RST_CODE(GT_HIGH)) u_gate_cfg (
      .clk(clk), .rst_n(rst_n), .we(gate_cfg_we), .wbyte(gate_cfg_byte),
      .codes(gate_codes)
   );

   ctr_route_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .din(ext_clk), .lvl(eclk_lvl), .rise(eclk_rise)
   );

   ctr_route_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync_gate (
      .clk(clk), .rst_n(rst_n), .din(ext_gate), .lvl(egate_lvl), .rise(egate_rise)
   );

   // counter outputs are synchronous to clk: one flop marks their rising edge;
   // reset to ones so a level already high at reset release is not an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctr_q <= '1;
      else        ctr_q <= ctr_out;
   end
   assign ctr_rise = ctr_out & ~ctr_q;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
      localparam int PRV1 = (i + NUM_CH - 1) % NUM_CH;
      localparam int PRV2 = (i + 2*NUM_CH - 2) % NUM_CH;
      ctr_route_lane u_lane (
         .taps      (taps),
         .clk_code  (clk_codes[i*CODE_W +: CODE_W]),
         .gate_code (gate_codes[i*CODE_W +: CODE_W]),
         .prev_rise (ctr_rise[PRV1]),
         .ext_rise  (eclk_rise[i]),
         .ext_lvl   (egate_lvl[i]),
         .prev2_out (ctr_out[PRV2]),
         .clk_en    (ch_clk_en[i]),
         .gate      (ch_gate[i])
      );
   end

   logic unused_ok;
   assign unused_ok = ^{eclk_lvl, egate_rise};
endmodule

// File: rtl/ctr_src_router_chk.sv
module ctr_src_router_chk
   import ctr_route_pkg::*;
#(
   parameter int NUM_CH = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     clk_cfg_we,
   input logic [7:0]               clk_cfg_byte,
   input logic                     gate_cfg_we,
   input logic [NUM_CH*CODE_W-1:0] clk_codes,
   input logic [NUM_CH*CODE_W-1:0] gate_codes,
   input logic [NUM_CH-1:0]        ctr_out,
   input logic [NUM_CH-1:0]        ch_clk_en,
   input logic [NUM_CH-1:0]        ch_gate
);
   // R2: out-of-range channel index leaves every selection alone
   a_r2_oob_write: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_cfg_we && (int'(clk_cfg_byte[4:3]) >= NUM_CH)) |=> $stable(clk_codes));

   // R11: clock writes never disturb gate selections
   a_r11_indep: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_cfg_we && !gate_cfg_we) |=> $stable(gate_codes));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam int P2 = (i + 2*NUM_CH - 2) % NUM_CH;
      logic [CODE_W-1:0] cc, gc;
      assign cc = clk_codes[i*CODE_W +: CODE_W];
      assign gc = gate_codes[i*CODE_W +: CODE_W];

      a_r3_base_every: assert property (@(posedge clk) disable iff (!rst_n)
         (cc == CK_BASE) |-> ch_clk_en[i]);
      a_r4_rsvd_silent: assert property (@(posedge clk) disable iff (!rst_n)
         (cc == CK_RSVD) |-> !ch_clk_en[i]);
      a_r5_prev_once: assert property (@(posedge clk) disable iff (!rst_n)
         (cc == CK_PREV && ch_clk_en[i]) |=> !(ch_clk_en[i] && cc == CK_PREV));
      a_r6_ext_once: assert property (@(posedge clk) disable iff (!rst_n)
         (cc == CK_EXT && ch_clk_en[i]) |=> !(ch_clk_en[i] && cc == CK_EXT));
      a_r7_gate_high: assert property (@(posedge clk) disable iff (!rst_n)
         (gc == GT_HIGH) |-> ch_gate[i]);
      a_r7_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
         (gc == GT_LOW) |-> !ch_gate[i]);
      a_r9_inv_neighbour: assert property (@(posedge clk) disable iff (!rst_n)
         (gc == GT_NPRV2) |-> (ch_gate[i] == !ctr_out[P2]));
      a_r10_undef_gate: assert property (@(posedge clk) disable iff (!rst_n)
         (gc[2]) |-> !ch_gate[i]);
   end
endmodule

bind ctr_src_router ctr_src_router_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .clk_cfg_we   (clk_cfg_we),
   .clk_cfg_byte (clk_cfg_byte),
   .gate_cfg_we  (gate_cfg_we),
   .clk_codes    (clk_codes),
   .gate_codes   (gate_codes),
   .ctr_out      (ctr_out),
   .ch_clk_en    (ch_clk_en),
   .ch_gate      (ch_gate)
);

// File: tb/ctr_src_router_bench.sv
module ctr_src_router_bench;
   localparam int N = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         clk_cfg_we = 1'b0;
   logic [7:0]   clk_cfg_byte = '0;
   logic         gate_cfg_we = 1'b0;
   logic [7:0]   gate_cfg_byte = '0;
   logic [N-1:0] ctr_out = '0;
   logic [N-1:0] ext_clk = '0;
   logic [N-1:0] ext_gate = '0;
   logic [N-1:0] ch_clk_en;
   logic [N-1:0] ch_gate;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ctr_src_router u_ctr_src_router (
      .clk(clk), .rst_n(rst_n),
      .clk_cfg_we(clk_cfg_we), .clk_cfg_byte(clk_cfg_byte),
      .gate_cfg_we(gate_cfg_we), .gate_cfg_byte(gate_cfg_byte),
      .ctr_out(ctr_out), .ext_clk(ext_clk), .ext_gate(ext_gate),
      .ch_clk_en(ch_clk_en), .ch_gate(ch_gate)
   );

   // gate table entry: {ch[1:0], code[2:0], ctr_out[2:0], ext_gate[2:0], expected}
   localparam int NV = 12;
   localparam logic [11:0] GVEC [NV] = '{
      {2'd0, 3'd0, 3'b000, 3'b000, 1'b1},
      {2'd0, 3'd1, 3'b000, 3'b000, 1'b0},
      {2'd1, 3'd2, 3'b000, 3'b010, 1'b1},
      {2'd1, 3'd2, 3'b000, 3'b000, 1'b0},
      {2'd0, 3'd3, 3'b010, 3'b000, 1'b0},
      {2'd0, 3'd3, 3'b000, 3'b000, 1'b1},
      {2'd1, 3'd3, 3'b100, 3'b000, 1'b0},
      {2'd2, 3'd3, 3'b001, 3'b000, 1'b0},
      {2'd2, 3'd3, 3'b110, 3'b000, 1'b1},
      {2'd2, 3'd4, 3'b000, 3'b111, 1'b0},
      {2'd1, 3'd7, 3'b000, 3'b111, 1'b0},
      {2'd0, 3'd5, 3'b000, 3'b111, 1'b0}
   };

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic wr_clk(input int ch, input int code);
      @(negedge clk);
      clk_cfg_we = 1'b1;
      clk_cfg_byte = {3'b000, 2'(ch), 3'(code)};
      @(negedge clk);
      clk_cfg_we = 1'b0;
   endtask

   task automatic wr_gate(input int ch, input int code);
      @(negedge clk);
      gate_cfg_we = 1'b1;
      gate_cfg_byte = {3'b000, 2'(ch), 3'(code)};
      @(negedge clk);
      gate_cfg_we = 1'b0;
   endtask

   task automatic count_en(input int ch, input int ncyc, output int c);
      c = 0;
      for (int k = 0; k < ncyc; k++) begin
         @(negedge clk);
         if (ch_clk_en[ch]) c++;
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      int c;
      string tag;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check("R1", "clock enables after reset", int'(ch_clk_en), 7);
      check("R1", "gates after reset", int'(ch_gate), 7);
      count_en(2, 20, c);
      check("R1", "ch2 base rate", c, 20);

      // R2: channel index 3 addresses nothing
      wr_clk(3, 0);
      for (int ch = 0; ch < N; ch++) begin
         count_en(ch, 10, c);
         check("R2", $sformatf("ch%0d after out-of-range write", ch), c, 10);
      end
      // R2/R4: addressed channel only
      wr_clk(1, 0);
      count_en(0, 10, c);
      check("R2", "ch0 untouched", c, 10);
      count_en(2, 10, c);
      check("R2", "ch2 untouched", c, 10);
      count_en(1, 200, c);
      check("R4", "reserved code pulses", c, 0);

      // gate table walk (R7, R8, R9, R10)
      for (int k = 0; k < NV; k++) begin
         logic [11:0] e;
         e = GVEC[k];
         @(negedge clk);
         ctr_out  = e[6:4];
         ext_gate = e[3:1];
         wr_gate(int'(e[11:10]), int'(e[9:7]));
         repeat (3) @(negedge clk);
         case (e[9:7])
            3'd0, 3'd1: tag = "R7";
            3'd2:       tag = "R8";
            3'd3:       tag = "R9";
            default:    tag = "R10";
         endcase
         check(tag, $sformatf("gate vector %0d", k), int'(ch_gate[e[11:10]]), int'(e[0]));
      end
      ctr_out = '0;
      ext_gate = '0;

      // R11: gate writes left clock selection of ch0 at base rate
      count_en(0, 10, c);
      check("R11", "ch0 clock after gate writes", c, 10);

      // R8: latency of external gate
      wr_gate(1, 2);
      repeat (3) @(negedge clk);
      ext_gate[1] = 1'b1;
      @(negedge clk);
      check("R8", "gate after one edge", int'(ch_gate[1]), 0);
      @(negedge clk);
      check("R8", "gate after two edges", int'(ch_gate[1]), 1);

      // R3: prescaler rates
      wr_clk(0, 2);
      count_en(0, 1000, c);
      check("R3", "1/10 rate", c, 100);
      wr_clk(1, 3);
      count_en(1, 1000, c);
      check("R3", "1/100 rate", c, 10);
      wr_clk(2, 4);
      count_en(2, 10000, c);
      check("R3", "1/1000 rate", c, 10);
      wr_clk(0, 5);
      count_en(0, 20000, c);
      check("R3", "1/10000 rate", c, 2);

      // R5: neighbour clock, ch1 from ctr_out[0]
      wr_clk(1, 6);
      ctr_out = '0;
      repeat (2) @(negedge clk);
      ctr_out[0] = 1'b1;
      #1;
      check("R5", "ch1 enable on rise", int'(ch_clk_en[1]), 1);
      @(negedge clk);
      check("R5", "ch1 enable while high", int'(ch_clk_en[1]), 0);
      // R5: wrap, ch0 from ctr_out[2]
      wr_clk(0, 6);
      repeat (2) @(negedge clk);
      ctr_out[2] = 1'b1;
      #1;
      check("R5", "ch0 enable on ch2 rise", int'(ch_clk_en[0]), 1);
      ctr_out = '0;

      // R6: external clock
      wr_clk(2, 7);
      repeat (3) @(negedge clk);
      ext_clk[2] = 1'b1;
      @(negedge clk);
      check("R6", "ext pulse after one edge", int'(ch_clk_en[2]), 0);
      @(negedge clk);
      check("R6", "ext pulse after two edges", int'(ch_clk_en[2]), 1);
      @(negedge clk);
      check("R6", "ext pulse ends", int'(ch_clk_en[2]), 0);
      count_en(2, 20, c);
      check("R6", "no pulse while held high", c, 0);

      done = 1'b1;
      finish_run();
   end
endmodule